// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Engine

This block is the target-side protocol engine of a two-wire serial memory. It samples the SCL and SDA lines in the system clock domain. Each line passes through a synchronizer and a majority filter before the engine looks for edges. From these edges it finds start and stop conditions, shifts received bits in on SCL rising edges, and changes its own SDA output only after SCL falls. SDA is open-drain: the engine pulls the line low or releases it.

After a start condition the engine checks the device byte against its two strap inputs. For a write it collects a two-byte word address and then strobes each data byte into a memory-side port. For a read it requests bytes from that port and shifts them out for as long as the controller keeps acknowledging. An internal address counter keeps its value from one transaction to the next. This gives current-address reads, and random reads made of a dummy write followed by a repeated start. Read addresses wrap across the whole array. Write addresses wrap inside a 64-byte page.

Top module: `eep_target_engine`

## Requirements
- R1: After reset the engine is idle and leaves SDA released. A start condition (SDA falling while SCL is high) in any state, even in the middle of a byte, abandons the transfer with no memory strobe and waits for a new device byte. A stop condition (SDA rising while SCL is high) returns the engine to idle.
- R2: The device byte is sent MSB first as bits 7..3 = 10100, bits 2..1 = strap_i[1:0] and bit 0 = direction (1 read, 0 write). On a match the engine pulls SDA low for the whole ninth SCL clock.
- R3: If the device byte does not match, the engine gives no acknowledge. It issues no write or read strobe and ignores every later byte until the next start.
- R4: A write first takes the high word-address byte and then the low one, and acknowledges each. Address bits at or above AW (15 by default) are ignored.
- R5: Each data byte after the word address gives exactly one mem_we_o pulse, carrying the current address and the byte, and is acknowledged.
- R6: After each written byte, only the low 6 address bits increment. They wrap from the last byte of a page to the first byte of the same page.
- R7: A read without a preceding word address returns the byte at the last accessed address plus one. This holds after a write as well as after a read.
- R8: A write device byte and a word address, followed by a repeated start and a read device byte, returns the byte at that word address.
- R9: A read continues with the next address while the controller acknowledges each byte. The address wraps from 2^AW-1 to 0.
- R10: A controller NACK ends the read. No further read request is issued, and the counter is left at the last byte sent plus one.
- R11: Read data goes out MSB first. SDA output changes only while SCL is low.
- R12: A pulse of one system clock on SCL or SDA is filtered out and has no effect on the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_i | input | 2 | Device select straps compared to device byte bits 2..1 |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_re_o | output | 1 | One-cycle read request; data expected on the next cycle |
| mem_addr_o | output | AW | Address for the strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid the cycle after mem_re_o |

## Verification
The hardest states to reach are the read wrap at the top of the array and a start that arrives after only half a byte has been shifted in. The bench reaches the wrap with a dummy write to 0x7FFE and then a sequential read across the end of the array. It reaches the abort by clocking four bits of a word-address byte and then issuing a repeated start. The page wrap comes from writing three bytes starting at the last byte of a page. The filter is tested by single-cycle pulses placed inside SCL high phases. On a '1' bit the pulse is on SDA, where it would otherwise look like a start. On a '0' bit the pulse is on SCL.

// File: rtl/eep_pkg.sv
`timescale 1ns/1ps
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WR,
    ST_RD
  } eep_state_e;

  localparam logic [4:0] DEV_TAG = 5'b10100;
endpackage

// File: rtl/eep_line_filter.sv
`timescale 1ns/1ps
module eep_line_filter #(
  parameter int unsigned SYNC = 2,
  parameter int unsigned TAPS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  logic [SYNC-1:0] sync_q;
  logic [TAPS-1:0] win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      win_q  <= '1;
      line_o <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], line_i};
      win_q  <= {win_q[TAPS-2:0], sync_q[SYNC-1]};
      line_o <= ($countones(win_q) > (TAPS / 2));
    end
  end
endmodule

// File: rtl/eep_bus_cond.sv
`timescale 1ns/1ps
module eep_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

  AST_COND_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({scl_rise_o, scl_fall_o, start_o, stop_o})); // R1
endmodule

// File: rtl/eep_addr_ctr.sv
`timescale 1ns/1ps
module eep_addr_ctr #(
  parameter int unsigned AW = 15,
  parameter int unsigned PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_wr_i,
  input  logic          inc_rd_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] q;
  logic [PW-1:0] low_nxt;

  assign low_nxt = q[PW-1:0] + {{(PW-1){1'b0}}, 1'b1};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q <= '0;
    else if (load_i)   q <= load_val_i;
    else if (inc_wr_i) q <= {q[AW-1:PW], low_nxt};
    else if (inc_rd_i) q <= q + {{(AW-1){1'b0}}, 1'b1};
  end

  assign addr_o = q;

  AST_PAGE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_wr_i && !load_i) |=> (addr_o[AW-1:PW] == $past(addr_o[AW-1:PW]))); // R6
endmodule

// File: rtl/eep_target_engine.sv
`timescale 1ns/1ps
module eep_target_engine
  import eep_pkg::*;
#(
  parameter int unsigned AW   = 15,
  parameter int unsigned PW   = 6,
  parameter int unsigned SYNC = 2,
  parameter int unsigned TAPS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [1:0]    strap_i,
  output logic          mem_we_o,
  output logic          mem_re_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i
);
  localparam int unsigned HIW = AW - 8;

  logic [1:0] raw_lines, filt_lines;
  logic       scl_f, sda_f;
  logic       scl_rise, scl_fall, start, stop;

  assign raw_lines = {scl_i, sda_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    eep_line_filter #(.SYNC(SYNC), .TAPS(TAPS)) u_filt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .line_i(raw_lines[g]),
      .line_o(filt_lines[g])
    );
  end

  assign scl_f = filt_lines[1];
  assign sda_f = filt_lines[0];

  eep_bus_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_f),
    .sda_i     (sda_f),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall),
    .start_o   (start),
    .stop_o    (stop)
  );

  eep_state_e      state_q;
  logic [3:0]      bit_q;
  logic [7:0]      rx_q, tx_q, rbuf_q, wdata_q;
  logic [HIW-1:0]  ahi_q;
  logic            oe_q, we_q, re_q, rd_pend_q, rw_q, mack_q;
  logic [AW-1:0]   maddr_q, ctr;
  logic            dev_hit, byte_end, ld_addr, inc_wr, inc_rd;

  assign dev_hit  = (rx_q[7:3] == DEV_TAG) && (rx_q[2:1] == strap_i);
  assign byte_end = scl_fall && (bit_q == 4'd8);
  assign ld_addr  = byte_end && (state_q == ST_ALO);
  assign inc_wr   = byte_end && (state_q == ST_WR);
  assign inc_rd   = scl_fall && (bit_q == 4'd9) &&
                    (((state_q == ST_DEV) && rw_q) || ((state_q == ST_RD) && mack_q));

  eep_addr_ctr #(.AW(AW), .PW(PW)) u_ctr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (ld_addr),
    .load_val_i({ahi_q, rx_q}),
    .inc_wr_i  (inc_wr),
    .inc_rd_i  (inc_rd),
    .addr_o    (ctr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_q     <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      rbuf_q    <= '0;
      wdata_q   <= '0;
      ahi_q     <= '0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      rd_pend_q <= 1'b0;
      rw_q      <= 1'b0;
      mack_q    <= 1'b0;
      maddr_q   <= '0;
    end else begin
      we_q      <= 1'b0;
      re_q      <= 1'b0;
      rd_pend_q <= re_q;
      if (rd_pend_q) rbuf_q <= mem_rdata_i;

      if (start) begin
        state_q <= ST_DEV;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop) begin
        state_q <= ST_IDLE;
        bit_q   <= '0;
        oe_q    <= 1'b0;
      end else if (scl_rise) begin
        if ((state_q inside {ST_DEV, ST_AHI, ST_ALO, ST_WR}) && (bit_q < 4'd8)) begin
          rx_q  <= {rx_q[6:0], sda_f};
          bit_q <= bit_q + 4'd1;
        end else if (state_q == ST_RD) begin
          if (bit_q < 4'd8) begin
            bit_q <= bit_q + 4'd1;
          end else if (bit_q == 4'd8) begin
            mack_q <= ~sda_f;
            bit_q  <= 4'd9;
            // prefetch the next byte only when the controller wants it
            if (!sda_f) begin
              re_q    <= 1'b1;
              maddr_q <= ctr;
            end
          end
        end
      end else if (scl_fall) begin
        case (state_q)
          ST_RD: begin
            if (bit_q == 4'd9) begin
              bit_q <= '0;
              if (mack_q) begin
                tx_q <= rbuf_q;
                oe_q <= ~rbuf_q[7];
              end else begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
              end
            end else if (bit_q == 4'd8) begin
              oe_q <= 1'b0;
            end else if (bit_q != 4'd0) begin
              oe_q <= ~tx_q[3'd7 - bit_q[2:0]];
            end
          end
          ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
            if (bit_q == 4'd8) begin
              if ((state_q == ST_DEV) && !dev_hit) begin
                state_q <= ST_IDLE;
              end else begin
                oe_q  <= 1'b1;
                bit_q <= 4'd9;
              end
              case (state_q)
                ST_DEV: begin
                  rw_q <= rx_q[0];
                  if (dev_hit && rx_q[0]) begin
                    re_q    <= 1'b1;
                    maddr_q <= ctr;
                  end
                end
                ST_AHI: ahi_q <= rx_q[HIW-1:0];
                ST_WR: begin
                  we_q    <= 1'b1;
                  maddr_q <= ctr;
                  wdata_q <= rx_q;
                end
                default: ;
              endcase
            end else if (bit_q == 4'd9) begin
              oe_q  <= 1'b0;
              bit_q <= '0;
              case (state_q)
                ST_DEV: begin
                  if (rw_q) begin
                    state_q <= ST_RD;
                    tx_q    <= rbuf_q;
                    oe_q    <= ~rbuf_q[7];
                  end else begin
                    state_q <= ST_AHI;
                  end
                end
                ST_AHI:  state_q <= ST_ALO;
                ST_ALO:  state_q <= ST_WR;
                default: ;
              endcase
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign mem_we_o    = we_q;
  assign mem_re_o    = re_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = wdata_q;

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_f); // R11
  AST_WE_ACKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> sda_oe_o); // R5
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mem_we_o, mem_re_o})); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!mem_we_o && !mem_re_o && !sda_oe_o)); // R3
  AST_START_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> !sda_oe_o); // R1
endmodule

// File: tb/eep_target_engine_tb_top.sv
`timescale 1ns/1ps
module eep_target_engine_tb_top;
  localparam int AW = 15;
  localparam int TQ = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, scl_gl = 1'b0, sda_gl = 1'b0;
  logic [1:0] strap = 2'b10;
  logic sda_oe, we, re;
  logic [AW-1:0] maddr;
  logic [7:0] wdata, rdata = 8'h00;
  logic scl_line, sda_line;

  int vectors = 0, errs = 0;
  int wr_cnt = 0, re_cnt = 0, last_wa = 0, last_wd = 0, r11_viol = 0;
  logic [7:0] mem [int];

  always #2 clk = ~clk;

  assign scl_line = scl_m & ~scl_gl;
  assign sda_line = sda_m & ~sda_gl & ~sda_oe;

  eep_target_engine #(.AW(AW)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_line),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .strap_i    (strap),
    .mem_we_o   (we),
    .mem_re_o   (re),
    .mem_addr_o (maddr),
    .mem_wdata_o(wdata),
    .mem_rdata_i(rdata)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a) ^ 8'((a >> 8) & 8'h7f);
  endfunction

  function automatic logic [7:0] peek(int a);
    if (mem.exists(a)) return mem[a];
    return pat(a);
  endfunction

  always @(posedge clk) begin
    if (we) begin
      mem[int'(maddr)] = wdata;
      wr_cnt++;
      last_wa = int'(maddr);
      last_wd = int'(wdata);
    end
    if (re) re_cnt++;
    rdata <= peek(int'(maddr));
  end

  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (sda_oe != oe_prev && scl_m) r11_viol++;
    oe_prev = sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wclk(TQ);
    scl_m = 1'b1; wclk(TQ);
    sda_m = 1'b0; wclk(TQ);
    scl_m = 1'b0; wclk(TQ);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wclk(TQ);
    scl_m = 1'b1; wclk(TQ);
    sda_m = 1'b1; wclk(TQ);
  endtask

  task automatic send_bit(input logic b, input bit gl);
    sda_m = b; wclk(TQ);
    scl_m = 1'b1; wclk(TQ);
    if (gl) begin
      if (b) sda_gl = 1'b1; else scl_gl = 1'b1;
      wclk(1);
      sda_gl = 1'b0; scl_gl = 1'b0;
      wclk(TQ - 1);
    end else begin
      wclk(TQ);
    end
    scl_m = 1'b0; wclk(TQ);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit gl, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], gl);
    sda_m = 1'b1; wclk(TQ);
    scl_m = 1'b1; wclk(TQ);
    ack = ~sda_line;
    wclk(TQ);
    scl_m = 1'b0; wclk(TQ);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit do_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wclk(TQ);
      scl_m = 1'b1; wclk(TQ);
      b[i] = sda_line;
      wclk(TQ);
      scl_m = 1'b0; wclk(TQ);
    end
    sda_m = ~do_ack; wclk(TQ);
    scl_m = 1'b1; wclk(2 * TQ);
    scl_m = 1'b0; wclk(TQ);
    sda_m = 1'b1;
  endtask

  int exp_ctr = 0;

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R1 reset sda released", sda_oe, 0);
    chk(we == 1'b0 && re == 1'b0, "R1 reset no strobe", {we, re}, 0);
  endtask

  task automatic t_byte_write();
    bit a;
    int w0 = wr_cnt;
    bus_start();
    send_byte(8'hA4, 0, a); chk(a, "R2 dev write ack", a, 1);
    send_byte(8'h12, 0, a); chk(a, "R4 addr hi ack", a, 1);
    send_byte(8'h34, 0, a); chk(a, "R4 addr lo ack", a, 1);
    send_byte(8'h5A, 0, a); chk(a, "R5 data ack", a, 1);
    bus_stop();
    chk(wr_cnt == w0 + 1, "R5 one strobe", wr_cnt - w0, 1);
    chk(last_wa == 'h1234 && last_wd == 'h5A, "R5 write addr/data", last_wa, 'h1234);
    exp_ctr = 'h1235;
  endtask

  task automatic t_current_read(input string tag);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA5, 0, a); chk(a, "R2 dev read ack", a, 1);
    recv_byte(d, 0);
    chk(d == pat(exp_ctr) || d == peek(exp_ctr), tag, d, peek(exp_ctr));
    bus_stop();
    exp_ctr = (exp_ctr + 1) & ((1 << AW) - 1);
  endtask

  task automatic t_random_seq_wrap();
    bit a;
    logic [7:0] d;
    int r0;
    bus_start();
    send_byte(8'hA4, 0, a);
    send_byte(8'h7F, 0, a);
    send_byte(8'hFE, 0, a); chk(a, "R8 dummy addr ack", a, 1);
    bus_start();
    r0 = re_cnt;
    send_byte(8'hA5, 0, a); chk(a, "R8 repeated start ack", a, 1);
    recv_byte(d, 1); chk(d == peek('h7FFE), "R8 random read", d, peek('h7FFE));
    recv_byte(d, 1); chk(d == peek('h7FFF), "R9 sequential next", d, peek('h7FFF));
    recv_byte(d, 0); chk(d == peek('h0000), "R9 wrap to zero", d, peek('h0000));
    bus_stop();
    chk(re_cnt == r0 + 3, "R10 no request after nack", re_cnt - r0, 3);
    exp_ctr = 'h0001;
    t_current_read("R10 counter after nack");
  endtask

  task automatic t_page_write();
    bit a;
    bus_start();
    send_byte(8'hA4, 0, a);
    send_byte(8'h00, 0, a);
    send_byte(8'hBF, 0, a);
    send_byte(8'h11, 0, a);
    send_byte(8'h22, 0, a);
    send_byte(8'h33, 0, a); chk(a, "R6 third data ack", a, 1);
    bus_stop();
    chk(peek('hBF) == 8'h11, "R6 first in page", peek('hBF), 'h11);
    chk(peek('h80) == 8'h22, "R6 page wrap", peek('h80), 'h22);
    chk(peek('h81) == 8'h33, "R6 after wrap", peek('h81), 'h33);
    exp_ctr = 'h82;
    t_current_read("R7 read after write");
  endtask

  task automatic t_mask();
    bit a;
    bus_start();
    send_byte(8'hA4, 0, a);
    send_byte(8'h92, 0, a);
    send_byte(8'h00, 0, a);
    send_byte(8'h3C, 0, a);
    bus_stop();
    chk(last_wa == 'h1200 && last_wd == 'h3C, "R4 high bits ignored", last_wa, 'h1200);
    exp_ctr = 'h1201;
  endtask

  task automatic t_mismatch();
    bit a;
    int w0 = wr_cnt, r0 = re_cnt;
    bus_start();
    send_byte(8'hA2, 0, a); chk(!a, "R3 no ack on mismatch", a, 0);
    send_byte(8'h55, 0, a);
    send_byte(8'h66, 0, a);
    send_byte(8'h77, 0, a); chk(!a, "R3 later bytes ignored", a, 0);
    bus_stop();
    chk(wr_cnt == w0 && re_cnt == r0, "R3 no strobes", wr_cnt - w0, 0);
  endtask

  task automatic t_abort();
    bit a;
    logic [7:0] d;
    int w0 = wr_cnt;
    bus_start();
    send_byte(8'hA4, 0, a);
    send_byte(8'h05, 0, a);
    for (int i = 7; i >= 4; i--) send_bit(1'(8'h44 >> i), 0);
    bus_start();
    send_byte(8'hA5, 0, a); chk(a, "R1 ack after abort", a, 1);
    recv_byte(d, 0);
    chk(d == peek(exp_ctr), "R1 counter kept by abort", d, peek(exp_ctr));
    bus_stop();
    chk(wr_cnt == w0, "R1 no write on abort", wr_cnt - w0, 0);
    exp_ctr = exp_ctr + 1;
  endtask

  task automatic t_glitch();
    bit a;
    bus_start();
    send_byte(8'hA4, 0, a);
    send_byte(8'h02, 0, a);
    send_byte(8'h10, 0, a);
    send_byte(8'hC3, 1, a); chk(a, "R12 ack through glitches", a, 1);
    bus_stop();
    chk(last_wa == 'h0210 && last_wd == 'hC3, "R12 data through glitches", last_wd, 'hC3);
  endtask

  initial begin
    wclk(5);
    rst_n = 1'b1;
    wclk(5);
    t_reset();
    t_byte_write();
    t_current_read("R7 current address read");
    t_random_seq_wrap();
    t_page_write();
    t_mask();
    t_mismatch();
    t_abort();
    t_glitch();
    chk(r11_viol == 0, "R11 sda changes only with scl low", r11_viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    wclk(150000);
    vectors++;
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule